// File: doc/BRIEF.md
# Bounding Interval Refit Engine

This engine recomputes the child bounding intervals of a binary bounded-KD hierarchy after leaf geometry has moved. The tree shape, child links and split axes stay fixed; only the bound values are refreshed. A producer streams node records with children always ahead of their parents. Each record is either a leaf that carries the 3D box of its single primitive, or an inner node that names its two children and its split axis. For every record the engine writes one updated record back out. That record holds a low/high interval for each child, taken along the node's own split axis.

Each node also needs the full 3D extent of its children. The engine keeps these extents in a small buffer indexed by node id: every record stores its own box there when it is accepted, and its parent reads the box later. The engine takes one record and issues one record per clock cycle. An update pass starts with a start pulse. It ends when the record flagged as root has been written out, and done then rises one cycle later.

Top module: `interval_refit`

## Requirements
- R1: After reset, outValid, done and inReady are all low.
- R2: Before a start pulse, inReady stays low, and records presented on the input are ignored: no output record appears.
- R3: For a leaf record (inLeaf=1), the output left and right intervals both equal the primitive's low/high on the axis given by inAxis. The primitive's 3D box becomes the leaf's stored extent.
- R4: For an inner record, the left interval is the left child's stored extent projected on the node's axis, and the right interval is the right child's. The node's stored extent is the per-axis union of both children's extents: the minimum of the lows and the maximum of the highs.
- R5: Axis code 0 selects lane x (bits W-1:0 of the packed boxes), 1 selects y (bits 2W-1:W), and 2 selects z (bits 3W-1:2W). Code 3 is treated as z.
- R6: Coordinates are signed two's-complement W-bit values, and every minimum and maximum is a signed comparison.
- R7: With outReady held high, a record is accepted every cycle, and each accepted record appears on the output in the cycle after it is accepted.
- R8: While outValid is high and outReady is low, the output record holds steady. No record is lost, duplicated or reordered.
- R9: The node id, leaf flag and root flag reach the output unchanged.
- R10: done rises in the cycle after the root record's output handshake and stays high until the next start. inReady is low from the cycle after the root is accepted until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins an update pass |
| done | output | 1 | High once the root record has been written |
| inValid | input | 1 | Input record valid |
| inReady | output | 1 | Engine can take a record |
| inNodeId | input | ID_W | Id of this node |
| inLeaf | input | 1 | Record is a leaf |
| inRoot | input | 1 | Record is the root, the last of the pass |
| inAxis | input | 2 | Split axis code of the node |
| inLeftId | input | ID_W | Id of the left child (inner nodes) |
| inRightId | input | ID_W | Id of the right child (inner nodes) |
| inLo | input | 3*W | Primitive box lows, packed z,y,x (leaves) |
| inHi | input | 3*W | Primitive box highs, packed z,y,x (leaves) |
| outValid | output | 1 | Output record valid |
| outReady | input | 1 | Consumer takes the output record |
| outNodeId | output | ID_W | Id of the written node |
| outLeaf | output | 1 | Written node is a leaf |
| outRoot | output | 1 | Written node is the root |
| outLeftLo | output | W | Left child interval low |
| outLeftHi | output | W | Left child interval high |
| outRightLo | output | W | Right child interval low |
| outRightHi | output | W | Right child interval high |

## Verification
The assertions rely on the producer keeping its side of the stream. Every child must be sent before its parent, each node must be sent exactly once per pass, and exactly one record per pass must carry the root flag, as the last one. The stimulus is a fixed fifteen-node tree sent in two orders that both keep children ahead of parents. Leaf boxes are random and each keeps its low at or below its high, one leaf sits entirely in negative space, and output stalls are random.

// File: rtl/refit_pkg.sv
package refit_pkg;
  typedef struct packed {
    logic capture;  // load the output record registers
    logic commit;   // write this node's extent to the buffer
  } refitStrobe_t;

  localparam int LANES = 3;
endpackage

// File: rtl/refit_ctrl.sv
module refit_ctrl
  import refit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         inValid,
  input  logic         inRoot,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output logic         done,
  output refitStrobe_t strb
);
  logic busy;
  logic rootHeld;
  logic accept;

  assign inReady = busy && (!outValid || outReady);
  assign accept  = inValid && inReady;
  assign strb.capture = accept;
  assign strb.commit  = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      outValid <= 1'b0;
      rootHeld <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (!busy && start) busy <= 1'b1;
      else if (accept && inRoot) busy <= 1'b0;

      if (accept) begin
        outValid <= 1'b1;
        rootHeld <= inRoot;
      end else if (outReady) begin
        outValid <= 1'b0;
      end

      if (!busy && start) done <= 1'b0;
      else if (outValid && outReady && rootHeld) done <= 1'b1;
    end
  end
endmodule

// File: rtl/refit_dp.sv
module refit_dp
  import refit_pkg::*;
#(
  parameter int W    = 24,
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  refitStrobe_t      strb,
  input  logic [ID_W-1:0]   inNodeId,
  input  logic              inLeaf,
  input  logic              inRoot,
  input  logic [1:0]        inAxis,
  input  logic [ID_W-1:0]   inLeftId,
  input  logic [ID_W-1:0]   inRightId,
  input  logic [LANES*W-1:0] inLo,
  input  logic [LANES*W-1:0] inHi,
  output logic [ID_W-1:0]   outNodeId,
  output logic              outLeaf,
  output logic              outRoot,
  output logic [W-1:0]      outLeftLo,
  output logic [W-1:0]      outLeftHi,
  output logic [W-1:0]      outRightLo,
  output logic [W-1:0]      outRightHi
);
  localparam int DEPTH = 1 << ID_W;
  localparam int BOX_W = LANES * W;

  logic [BOX_W-1:0] extLo [DEPTH];
  logic [BOX_W-1:0] extHi [DEPTH];

  logic [BOX_W-1:0] lChildLo, lChildHi, rChildLo, rChildHi;
  logic [BOX_W-1:0] nodeLo, nodeHi;
  logic [BOX_W-1:0] leftSrcLo, leftSrcHi, rightSrcLo, rightSrcHi;

  function automatic logic [W-1:0] pickLane(input logic [BOX_W-1:0] box,
                                            input logic [1:0] axis);
    case (axis)
      2'd0:    pickLane = box[0 +: W];
      2'd1:    pickLane = box[W +: W];
      default: pickLane = box[2*W +: W];
    endcase
  endfunction

  assign lChildLo = extLo[inLeftId];
  assign lChildHi = extHi[inLeftId];
  assign rChildLo = extLo[inRightId];
  assign rChildHi = extHi[inRightId];

  for (genvar k = 0; k < LANES; k++) begin : g_union
    logic [W-1:0] aLo, bLo, aHi, bHi;
    assign aLo = lChildLo[k*W +: W];
    assign bLo = rChildLo[k*W +: W];
    assign aHi = lChildHi[k*W +: W];
    assign bHi = rChildHi[k*W +: W];
    assign nodeLo[k*W +: W] = inLeaf ? inLo[k*W +: W]
                            : (($signed(aLo) < $signed(bLo)) ? aLo : bLo);
    assign nodeHi[k*W +: W] = inLeaf ? inHi[k*W +: W]
                            : (($signed(aHi) > $signed(bHi)) ? aHi : bHi);
  end

  assign leftSrcLo  = inLeaf ? inLo : lChildLo;
  assign leftSrcHi  = inLeaf ? inHi : lChildHi;
  assign rightSrcLo = inLeaf ? inLo : rChildLo;
  assign rightSrcHi = inLeaf ? inHi : rChildHi;

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      extLo[inNodeId] <= nodeLo;
      extHi[inNodeId] <= nodeHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outNodeId  <= '0;
      outLeaf    <= 1'b0;
      outRoot    <= 1'b0;
      outLeftLo  <= '0;
      outLeftHi  <= '0;
      outRightLo <= '0;
      outRightHi <= '0;
    end else if (strb.capture) begin
      outNodeId  <= inNodeId;
      outLeaf    <= inLeaf;
      outRoot    <= inRoot;
      outLeftLo  <= pickLane(leftSrcLo, inAxis);
      outLeftHi  <= pickLane(leftSrcHi, inAxis);
      outRightLo <= pickLane(rightSrcLo, inAxis);
      outRightHi <= pickLane(rightSrcHi, inAxis);
    end
  end
endmodule

// File: rtl/interval_refit.sv
module interval_refit
  import refit_pkg::*;
#(
  parameter int W    = 24,
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ID_W-1:0]   inNodeId,
  input  logic              inLeaf,
  input  logic              inRoot,
  input  logic [1:0]        inAxis,
  input  logic [ID_W-1:0]   inLeftId,
  input  logic [ID_W-1:0]   inRightId,
  input  logic [3*W-1:0]    inLo,
  input  logic [3*W-1:0]    inHi,
  output logic              outValid,
  input  logic              outReady,
  output logic [ID_W-1:0]   outNodeId,
  output logic              outLeaf,
  output logic              outRoot,
  output logic [W-1:0]      outLeftLo,
  output logic [W-1:0]      outLeftHi,
  output logic [W-1:0]      outRightLo,
  output logic [W-1:0]      outRightHi
);
  refitStrobe_t strb;

  refit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inRoot(inRoot), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .done(done), .strb(strb)
  );

  refit_dp #(.W(W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inNodeId(inNodeId), .inLeaf(inLeaf), .inRoot(inRoot), .inAxis(inAxis),
    .inLeftId(inLeftId), .inRightId(inRightId), .inLo(inLo), .inHi(inHi),
    .outNodeId(outNodeId), .outLeaf(outLeaf), .outRoot(outRoot),
    .outLeftLo(outLeftLo), .outLeftHi(outLeftHi),
    .outRightLo(outRightLo), .outRightHi(outRightHi)
  );
endmodule

// File: rtl/interval_refit_chk.sv
module interval_refit_chk #(
  parameter int W    = 24,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            done,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [ID_W-1:0] outNodeId,
  input logic            outLeaf,
  input logic            outRoot,
  input logic [W-1:0]    outLeftLo,
  input logic [W-1:0]    outLeftHi,
  input logic [W-1:0]    outRightLo,
  input logic [W-1:0]    outRightHi
);
  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outNodeId) && $stable(outLeaf)
      && $stable(outRoot) && $stable(outLeftLo) && $stable(outLeftHi)
      && $stable(outRightLo) && $stable(outRightHi));

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady && outRoot));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady);

  // R3
  leaf_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLeaf |-> outLeftLo == outRightLo && outLeftHi == outRightHi);
endmodule

bind interval_refit interval_refit_chk #(.W(W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outNodeId(outNodeId),
  .outLeaf(outLeaf), .outRoot(outRoot), .outLeftLo(outLeftLo),
  .outLeftHi(outLeftHi), .outRightLo(outRightLo), .outRightHi(outRightHi)
);

// File: tb/interval_refit_test.sv
module interval_refit_test;
  localparam int W = 24;
  localparam int ID_W = 4;
  localparam int NN = 15;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic done;
  logic inValid = 0;
  logic inReady;
  logic [ID_W-1:0] inNodeId = '0;
  logic inLeaf = 0;
  logic inRoot = 0;
  logic [1:0] inAxis = '0;
  logic [ID_W-1:0] inLeftId = '0;
  logic [ID_W-1:0] inRightId = '0;
  logic [3*W-1:0] inLo = '0;
  logic [3*W-1:0] inHi = '0;
  logic outValid;
  logic outReady = 0;
  logic [ID_W-1:0] outNodeId;
  logic outLeaf, outRoot;
  logic [W-1:0] outLeftLo, outLeftHi, outRightLo, outRightHi;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  interval_refit #(.W(W), .ID_W(ID_W)) uut (.*);

  int nLeaf[NN], nAxis[NN], nL[NN], nR[NN];
  int bLo[NN][3], bHi[NN][3];
  int order[NN];
  int eLL[NN], eLH[NN], eRL[NN], eRH[NN];

  function automatic int rnd24();
    logic [23:0] t;
    t = 24'($urandom);
    return int'($signed(t));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic buildTree(input bit negLeaf);
    for (int i = 0; i < 8; i++) begin
      nLeaf[i] = 1; nAxis[i] = $urandom % 3; nL[i] = 0; nR[i] = 0;
      for (int k = 0; k < 3; k++) begin
        int a, b;
        a = rnd24(); b = rnd24();
        if (negLeaf && i == 5) begin a = -(a & 32'h3FFFFF) - 1; b = -(b & 32'h3FFFFF) - 1; end
        bLo[i][k] = (a < b) ? a : b;
        bHi[i][k] = (a < b) ? b : a;
      end
    end
    for (int i = 8; i < NN; i++) begin
      nLeaf[i] = 0; nAxis[i] = $urandom % 3;
      nL[i] = (i < 12) ? 2*(i-8) : 8 + 2*(i-12);
      nR[i] = nL[i] + 1;
      for (int k = 0; k < 3; k++) begin
        bLo[i][k] = (bLo[nL[i]][k] < bLo[nR[i]][k]) ? bLo[nL[i]][k] : bLo[nR[i]][k];
        bHi[i][k] = (bHi[nL[i]][k] > bHi[nR[i]][k]) ? bHi[nL[i]][k] : bHi[nR[i]][k];
      end
    end
    for (int i = 0; i < NN; i++) begin
      int ax;
      ax = nAxis[i];
      if (nLeaf[i] == 1) begin
        eLL[i] = bLo[i][ax]; eLH[i] = bHi[i][ax]; eRL[i] = bLo[i][ax]; eRH[i] = bHi[i][ax];
      end else begin
        eLL[i] = bLo[nL[i]][ax]; eLH[i] = bHi[nL[i]][ax];
        eRL[i] = bLo[nR[i]][ax]; eRH[i] = bHi[nR[i]][ax];
      end
    end
  endtask

  task automatic driveNode(input int n);
    inNodeId = ID_W'(n); inLeaf = nLeaf[n][0]; inRoot = (n == NN-1);
    inAxis = 2'(nAxis[n]); inLeftId = ID_W'(nL[n]); inRightId = ID_W'(nR[n]);
    for (int k = 0; k < 3; k++) begin
      inLo[k*W +: W] = W'(nLeaf[n] == 1 ? bLo[n][k] : 0);
      inHi[k*W +: W] = W'(nLeaf[n] == 1 ? bHi[n][k] : 0);
    end
  endtask

  task automatic runPass(input int stallPct, input string tag);
    int idx, got, stalls, held;
    bit fireIn, prevStall;
    logic [W-1:0] hLL;
    logic [ID_W-1:0] hId;
    idx = 0; got = 0; stalls = 0; prevStall = 0; held = 0; hLL = '0; hId = '0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; #1;
    check("R10", {tag, " done cleared by start"}, int'(done), 0);
    while (got < NN) begin
      @(negedge clk);
      outReady = (($urandom % 100) >= stallPct);
      if (idx < NN) begin driveNode(order[idx]); inValid = 1; end
      else inValid = 0;
      #1;
      if (prevStall) begin
        check("R8", {tag, " held id"}, int'(outNodeId), int'(hId));
        check("R8", {tag, " held low"}, int'(outLeftLo), int'(hLL));
      end
      if (inValid && !inReady && !(outValid && !outReady)) stalls++;
      if (outValid && outReady) begin
        int n;
        n = order[got];
        check("R9", {tag, " node order"}, int'(outNodeId), n);
        check("R9", {tag, " leaf flag"}, int'(outLeaf), nLeaf[n]);
        check("R9", {tag, " root flag"}, int'(outRoot), int'(n == NN-1));
        check(nLeaf[n] == 1 ? "R3" : "R4", {tag, " left lo (R5 R6)"}, int'($signed(outLeftLo)), eLL[n]);
        check(nLeaf[n] == 1 ? "R3" : "R4", {tag, " left hi"}, int'($signed(outLeftHi)), eLH[n]);
        check(nLeaf[n] == 1 ? "R3" : "R4", {tag, " right lo"}, int'($signed(outRightLo)), eRL[n]);
        check(nLeaf[n] == 1 ? "R3" : "R4", {tag, " right hi"}, int'($signed(outRightHi)), eRH[n]);
        got++;
        if (got == NN) check("R10", {tag, " done before root write"}, int'(done), 0);
      end
      prevStall = outValid && !outReady;
      hLL = outLeftLo; hId = outNodeId;
      fireIn = inValid && inReady;
      @(posedge clk);
      if (fireIn) idx++;
    end
    @(negedge clk); inValid = 0; #1;
    check("R10", {tag, " done after root"}, int'(done), 1);
    check("R10", {tag, " ready low after root"}, int'(inReady), 0);
    if (stallPct == 0) check("R7", {tag, " idle input cycles"}, stalls, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "inReady in reset", int'(inReady), 0);
    @(negedge clk); rstN = 1;
    buildTree(1'b1);
    driveNode(0); inValid = 1;
    repeat (4) @(negedge clk);
    #1;
    check("R2", "inReady before start", int'(inReady), 0);
    check("R2", "outValid before start", int'(outValid), 0);
    inValid = 0;
    for (int i = 0; i < NN; i++) order[i] = i;
    runPass(0, "pass1");
    buildTree(1'b0);
    order = '{0, 1, 8, 2, 3, 9, 12, 4, 5, 10, 6, 7, 11, 13, 14};
    runPass(40, "pass2");
    buildTree(1'b1);
    runPass(75, "pass3");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule